// File: doc/BRIEF.md
# Camera FIFO Burst Request Controller

This block lets an external DMA engine drain a byte-wide camera image buffer in fixed-size bursts. Image bytes go into an internal FIFO, each tagged with a flag that marks the last byte of the frame. When a full burst is buffered, or when the frame's last byte has been written, the block raises a request line toward the DMA engine. The engine then reads the data register once per byte. The request drops on the first read of each burst, so an engine that reacts to edges sees a fresh edge for every burst.

After the frame's last byte has been delivered, the remaining reads of that burst return the padding value 0x00 and consume nothing. The final read of that burst produces a one-cycle end-of-image pulse, and the burst counter restarts for the next frame. A read that finds the FIFO empty before the frame end is known returns padding and sets a sticky underrun flag. A halt input stops new requests so that software can flush pending work. Releasing halt resumes at the same burst position. The active level of the request line is set by a polarity input.

Top module: `cam_burst_dma`

## Requirements
- R1: After reset the request line sits at its inactive level (equal to `req_pol`), and `eoi_irq`, `underrun` and `rd_data` are 0.
- R2: With `halt` low, the request line goes to its active level (the inverse of `req_pol`) one cycle after the write that brings the FIFO to BURST entries, or that stores a frame-last byte. Below BURST entries and with no frame-last byte stored, it stays inactive.
- R3: The request returns to its inactive level at the clock edge that takes the first read of a burst.
- R4: Each data-register read in a burst returns, one cycle after the strobe, the oldest byte not yet read, in write order.
- R5: After BURST reads without delivering the frame-last byte, the block waits for the next burst and re-requests one cycle later if a burst is ready.
- R6: Reads that follow delivery of the frame-last byte, within the same burst, return 0x00 and consume no FIFO entry.
- R7: `eoi_irq` is high for exactly one cycle, one cycle after the final read of the burst that delivered the frame-last byte. This includes a frame whose length is a whole number of bursts.
- R8: `req_pol` = 0 makes the request active high. `req_pol` = 1 makes it active low.
- R9: A read made while the FIFO is empty, with no frame-last byte stored or delivered, returns 0x00 and sets `underrun`, which stays set until reset.
- R10: While `halt` is high the request stays inactive and no new burst starts. After `halt` falls, a pending request reappears and the next read returns the next byte of the same burst.
- R11: `wr_ready` is low while the FIFO holds DEPTH entries, and a write offered then is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Image byte offered to the FIFO |
| wr_data | input | 8 | Image byte |
| wr_last | input | 1 | Marks the offered byte as the frame's last |
| wr_ready | output | 1 | FIFO can accept a byte |
| rd_strobe | input | 1 | Data-register read, one per byte |
| rd_data | output | 8 | Byte returned by the last read |
| req_pol | input | 1 | Request polarity: 0 active high, 1 active low |
| halt | input | 1 | Suspends request generation |
| dreq | output | 1 | Burst request toward the DMA engine |
| eoi_irq | output | 1 | One-cycle end-of-image pulse |
| underrun | output | 1 | Sticky read-while-empty flag |

## Verification
A read taken at clock edge k shows its byte on `rd_data` after edge k+1. If it was the frame's final read, `eoi_irq` also rises after edge k+1 and falls after k+2. The request falls at edge k itself and, when another burst is ready, rises again after k+1. `halt` and `req_pol` act on the request line within the same cycle. The scoreboard gives every read an expected byte and pulse level, due at the cycle after the strobe, and compares them at the falling edge of that cycle. Request-line checks are made at the falling edge just after the write or read edge, and again one cycle later, to pin down the exact cycle of each change.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } seq_state_e;

endpackage

// File: rtl/cbd_fifo.sv
module cbd_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_last,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic              head_last,
  output logic [CW-1:0]     count,
  output logic              empty,
  output logic              full,
  output logic              last_pending
);

  logic [DATA_W:0] mem [DEPTH];
  logic [AW-1:0]   wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]   cnt_q, cnt_d, lcnt_q, lcnt_d;

  // storage: no reset, written only on accepted pushes
  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= {push_last, push_data};
  end

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (push) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
    if (pop)  rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);

    unique case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase

    unique case ({push && push_last, pop && mem[rptr_q][DATA_W]})
      2'b10:   lcnt_d = lcnt_q + CW'(1);
      2'b01:   lcnt_d = lcnt_q - CW'(1);
      default: lcnt_d = lcnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      lcnt_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      lcnt_q <= lcnt_d;
    end
  end

  assign head_data    = mem[rptr_q][DATA_W-1:0];
  assign head_last    = mem[rptr_q][DATA_W];
  assign count        = cnt_q;
  assign empty        = (cnt_q == '0);
  assign full         = (cnt_q == CW'(DEPTH));
  assign last_pending = (lcnt_q != '0);

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    push |-> (cnt_q < CW'(DEPTH)));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    pop |-> (cnt_q != '0));

  assert_last_bound_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    lcnt_q <= cnt_q);

endmodule

// File: rtl/cbd_seq.sv
module cbd_seq
  import cbd_pkg::*;
#(
  parameter int BURST = 16,
  localparam int BW   = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic rd_strobe,
  input  logic halt,
  input  logic burst_ready,
  input  logic fifo_empty,
  input  logic head_last,
  input  logic last_pending,
  output logic pop,
  output logic req_on,
  output logic eoi,
  output logic underrun_evt
);

  seq_state_e    st_q, st_d;
  logic [BW-1:0] beat_q, beat_d;
  logic          seen_q, seen_d;
  logic          eoi_q, eoi_d;
  logic          serve, delivered, burst_end;

  always_comb begin
    serve        = rd_strobe && (st_q != ST_WAIT);
    pop          = serve && !seen_q && !fifo_empty;
    underrun_evt = rd_strobe && fifo_empty && !last_pending && !seen_q;
    delivered    = seen_q || (pop && head_last);
    burst_end    = serve && (beat_q == BW'(BURST - 1));

    st_d   = st_q;
    beat_d = beat_q;
    seen_d = seen_q;
    eoi_d  = 1'b0;

    unique case (st_q)
      ST_WAIT: begin
        if (!halt && burst_ready) st_d = ST_REQ;
      end
      ST_REQ: begin
        if (serve) begin
          st_d   = ST_XFER;
          beat_d = BW'(1);
          seen_d = delivered;
        end
      end
      ST_XFER: begin
        if (burst_end) begin
          st_d   = ST_WAIT;
          beat_d = '0;
          seen_d = 1'b0;
          eoi_d  = delivered;
        end else if (serve) begin
          beat_d = beat_q + BW'(1);
          seen_d = delivered;
        end
      end
      default: st_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_WAIT;
      beat_q <= '0;
      seen_q <= 1'b0;
      eoi_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
      seen_q <= seen_d;
      eoi_q  <= eoi_d;
    end
  end

  assign req_on = (st_q == ST_REQ) && !halt;
  assign eoi    = eoi_q;

  assert_first_read_leaves_req_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_REQ && rd_strobe) |=> (st_q == ST_XFER));

  assert_eoi_single_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    eoi_q |=> !eoi_q);

  assert_halt_blocks_start_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_WAIT && halt) |=> (st_q == ST_WAIT));

  assert_burst_wraps_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_XFER && rd_strobe && beat_q == BW'(BURST - 1)) |=> (st_q == ST_WAIT && beat_q == '0));

  assert_pad_after_end_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (seen_q && rd_strobe) |-> !pop);

endmodule

// File: rtl/cam_burst_dma.sv
module cam_burst_dma #(
  parameter int          DATA_W = 8,
  parameter int          DEPTH  = 32,
  parameter int          BURST  = 16,
  parameter logic [DATA_W-1:0] PAD = '0,
  localparam int         CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  output logic              wr_ready,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  input  logic              req_pol,
  input  logic              halt,
  output logic              dreq,
  output logic              eoi_irq,
  output logic              underrun
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [DATA_W-1:0] head_data;
  logic              head_last, fifo_empty, fifo_full, last_pending;
  logic [CW-1:0]     fifo_count;
  logic              push, pop, req_on, eoi, underrun_evt, burst_ready;

  assign push        = wr_valid && !fifo_full;
  assign burst_ready = (fifo_count >= CW'(BURST)) || last_pending;

  cbd_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .push         (push),
    .push_data    (wr_data),
    .push_last    (wr_last),
    .pop          (pop),
    .head_data    (head_data),
    .head_last    (head_last),
    .count        (fifo_count),
    .empty        (fifo_empty),
    .full         (fifo_full),
    .last_pending (last_pending)
  );

  cbd_seq #(.BURST(BURST)) u_seq (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .rd_strobe    (rd_strobe),
    .halt         (halt),
    .burst_ready  (burst_ready),
    .fifo_empty   (fifo_empty),
    .head_last    (head_last),
    .last_pending (last_pending),
    .pop          (pop),
    .req_on       (req_on),
    .eoi          (eoi),
    .underrun_evt (underrun_evt)
  );

  // read data register and sticky underrun flag
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;
  logic              urun_q, urun_d;

  always_comb begin
    rdata_en = rd_strobe;
    rdata_d  = pop ? head_data : PAD;
    urun_d   = urun_q || underrun_evt;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      urun_q  <= 1'b0;
    end else begin
      if (rdata_en) rdata_q <= rdata_d;
      urun_q <= urun_d;
    end
  end

  assign wr_ready = !fifo_full;
  assign rd_data  = rdata_q;
  assign dreq     = req_on ^ req_pol;
  assign eoi_irq  = eoi;
  assign underrun = urun_q;

  assert_req_release_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    ((dreq != req_pol) && rd_strobe) |=> (dreq == req_pol));

  assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    urun_q |=> urun_q);

  assert_irq_follows_read_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    eoi_irq |-> $past(rd_strobe));

  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    halt |-> (dreq == req_pol));

endmodule

// File: tb/cam_burst_dma_test.sv
module cam_burst_dma_test;

  localparam int CLK_PERIOD = 10;
  localparam int BURST      = 16;
  localparam int DEPTH      = 32;

  logic       clk, rst_n, wr_valid, wr_last, wr_ready, rd_strobe;
  logic [7:0] wr_data, rd_data;
  logic       req_pol, halt, dreq, eoi_irq, underrun;

  cam_burst_dma #(.DATA_W(8), .DEPTH(DEPTH), .BURST(BURST), .PAD(8'h00)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_last(wr_last), .wr_ready(wr_ready), .rd_strobe(rd_strobe),
    .rd_data(rd_data), .req_pol(req_pol), .halt(halt), .dreq(dreq),
    .eoi_irq(eoi_irq), .underrun(underrun)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         due;
    logic [7:0] d;
    logic       irq;
    string      tag;
  } sb_item_t;

  sb_item_t   sb_q[$];
  logic [8:0] mdl_q[$];
  bit         frame_done = 0;
  int         bpos = 0;
  logic [7:0] seed = 8'h31;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares each read's byte and pulse in the cycle it is due
  always @(negedge clk) begin
    if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      sb_item_t it;
      it = sb_q.pop_front();
      chk({it.tag, " data"}, {24'd0, rd_data}, {24'd0, it.d});
      chk({it.tag, " irq"}, {31'd0, eoi_irq}, {31'd0, it.irq});
    end
  end

  task automatic write_byte(logic [7:0] d, logic last);
    @(negedge clk);
    if (wr_ready) mdl_q.push_back({last, d});
    wr_valid = 1'b1;
    wr_data  = d;
    wr_last  = last;
    @(negedge clk);
    wr_valid = 1'b0;
    wr_last  = 1'b0;
  endtask

  task automatic write_frame(int n, bit with_last);
    for (int i = 0; i < n; i++) begin
      seed = seed * 8'd5 + 8'd17;
      write_byte(seed, with_last && (i == n - 1));
    end
  endtask

  task automatic dma_read();
    sb_item_t it;
    logic [8:0] e;
    if (!frame_done && mdl_q.size() > 0) begin
      e = mdl_q.pop_front();
      it.d = e[7:0];
      it.tag = "R4";
      if (e[8]) frame_done = 1;
    end else begin
      it.d = 8'h00;
      it.tag = "R6";
    end
    it.irq = (bpos == BURST - 1) && frame_done;
    bpos = (bpos + 1) % BURST;
    if (it.irq) begin
      frame_done = 0;
      it.tag = "R7";
    end
    @(negedge clk);
    rd_strobe = 1'b1;
    it.due = cyc + 1;
    sb_q.push_back(it);
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic idle_read(string tag);
    sb_item_t it;
    it.d = 8'h00;
    it.irq = 1'b0;
    it.tag = tag;
    @(negedge clk);
    rd_strobe = 1'b1;
    it.due = cyc + 1;
    sb_q.push_back(it);
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; wr_last = 1'b0;
    rd_strobe = 1'b0; req_pol = 1'b0; halt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 dreq", {31'd0, dreq}, 32'd0);
    chk("R1 irq", {31'd0, eoi_irq}, 32'd0);
    chk("R1 rd_data", {24'd0, rd_data}, 32'd0);
    chk("R1 underrun", {31'd0, underrun}, 32'd0);
    chk("R1 wr_ready", {31'd0, wr_ready}, 32'd1);

    // R2: no request below a burst, request one cycle after the 16th byte
    write_frame(10, 0);
    repeat (2) @(negedge clk);
    chk("R2 below burst", {31'd0, dreq}, 32'd0);
    write_frame(6, 0);
    chk("R2 not yet", {31'd0, dreq}, 32'd0);
    @(negedge clk);
    chk("R2 raised", {31'd0, dreq}, 32'd1);
    // R3: released by the first read
    dma_read();
    chk("R3 released", {31'd0, dreq}, 32'd0);
    for (int i = 1; i < BURST; i++) dma_read();
    repeat (2) @(negedge clk);
    chk("R5 idle without data", {31'd0, dreq}, 32'd0);

    // R5/R6/R7: 20-byte frame, two bursts, tail padded
    write_frame(20, 1);
    @(negedge clk);
    for (int i = 0; i < BURST; i++) dma_read();
    chk("R5 wait after burst", {31'd0, dreq}, 32'd0);
    @(negedge clk);
    chk("R5 re-request", {31'd0, dreq}, 32'd1);
    for (int i = 0; i < BURST; i++) dma_read();
    @(negedge clk);
    chk("R7 pulse ends", {31'd0, eoi_irq}, 32'd0);
    chk("R7 no request after frame", {31'd0, dreq}, 32'd0);

    // R7: frame of exactly one burst
    write_frame(BURST, 1);
    @(negedge clk);
    for (int i = 0; i < BURST; i++) dma_read();
    @(negedge clk);
    chk("R7 exact pulse ends", {31'd0, eoi_irq}, 32'd0);

    // R8: active-low request
    req_pol = 1'b1;
    @(negedge clk);
    chk("R8 inactive high", {31'd0, dreq}, 32'd1);
    write_frame(5, 1);
    repeat (2) @(negedge clk);
    chk("R8 active low", {31'd0, dreq}, 32'd0);
    for (int i = 0; i < BURST; i++) dma_read();
    chk("R8 released high", {31'd0, dreq}, 32'd1);
    req_pol = 1'b0;

    // R10: halt blocks and resumes
    halt = 1'b1;
    write_frame(BURST, 1);
    repeat (3) @(negedge clk);
    chk("R10 halted idle", {31'd0, dreq}, 32'd0);
    halt = 1'b0;
    @(negedge clk);
    chk("R10 resumed", {31'd0, dreq}, 32'd1);
    halt = 1'b1;
    @(negedge clk);
    chk("R10 masked", {31'd0, dreq}, 32'd0);
    halt = 1'b0;
    @(negedge clk);
    chk("R10 back", {31'd0, dreq}, 32'd1);
    for (int i = 0; i < BURST; i++) dma_read();

    // R11: fill, drop the extra write, drain in order
    write_frame(DEPTH, 0);
    chk("R11 full", {31'd0, wr_ready}, 32'd0);
    write_byte(8'hEE, 1'b0);
    chk("R11 still full", {31'd0, wr_ready}, 32'd0);
    for (int i = 0; i < DEPTH; i++) dma_read();
    chk("R11 ready again", {31'd0, wr_ready}, 32'd1);
    repeat (2) @(negedge clk);
    chk("R11 extra dropped", {31'd0, dreq}, 32'd0);

    // R9: read while empty with no frame end
    chk("R9 clear before", {31'd0, underrun}, 32'd0);
    idle_read("R9");
    chk("R9 set", {31'd0, underrun}, 32'd1);
    repeat (4) @(negedge clk);
    chk("R9 sticky", {31'd0, underrun}, 32'd1);

    repeat (2) @(negedge clk);
    chk("scoreboard drained", sb_q.size(), 32'd0);
    summary();
  end

endmodule